// File: doc/BRIEF.md
# Trap and Interrupt Controller

This block holds the machine-control state of a small processor core: a status word, a cause word, the exception PC, the bad-address register, a floating-point status word and a free-running instruction counter with a compare register. On each instruction step it decides whether to take a trap. An interrupt is taken when a pending line is unmasked and traps are globally enabled. Otherwise a synchronous trap is taken when the pipeline requests one. When a trap is taken, the block updates status and cause in a single cycle.

The core drives `step_i` once per instruction, together with that instruction's PC. A synchronous trap is requested with `trap_req_i` and a trap number in the same cycle. Software updates the registers through one write port, selected by a 3-bit code. The trap decision, `trap_taken_o` with `trap_code_o`, is combinational from the current inputs and state. Every register takes its new value at the following clock edge.

All pins are plain control and status pins. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, status reads 0xA0, which is supervisor (bit 5) plus supervisor-wide enable (bit 7). Cause, EPC, bad address, count, compare, FSR and `error_o` are all zero.
- R2: An interrupt trap is taken only in a cycle with `step_i` high, trap-enable (status bit 0) set, and a nonzero AND of cause bits [15:8] with status bits [23:16]. It reports code `IRQ_CODE` (default 0).
- R3: On trap entry, trap-enable is cleared, supervisor (bit 5) is set, and previous-supervisor (bit 4) receives the old bit 5.
- R4: On trap entry, cause bits [4:0] take the trap code, cause bits [15:8] are kept, and EPC takes `pc_i`.
- R5: The bad-address register loads `fault_addr_i` only on a synchronous trap with `addr_fault_i` high.
- R6: A requested trap while trap-enable is clear, or with a number of `NUM_TRAPS` (16) or more, is not taken and sets the sticky `error_o`.
- R7: A status write keeps only the defined bits: 0, 4, 5 and [23:16], plus the feature bits that are configured. With the defaults these are FPU bit 1, user-wide bit 6 and supervisor-wide bit 7. The compressed-instruction bit 2 and the vector bit 3 are cleared. Cause writes keep only bits [15:8] and [4:0].
- R8: `xlen64_o` is status bit 7 when bit 5 is set, and status bit 6 otherwise.
- R9: Count increments once per step. If its value before the increment equals compare, cause bit 8+`TIMER_LINE` (bit 15) is set.
- R10: The timer pending bit stays set until a cause write clears it or compare is written.
- R11: An FSR write keeps only the bits in `FSR_KEEP` (0xFF). All other FSR bits read zero.
- R12: In a step where an interrupt is taken, a simultaneous synchronous request is dropped and raises no error.
- R13: In a trap-entry cycle, writes to status, cause, EPC and bad address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One instruction step this cycle |
| pc_i | input | DATA_W | PC of the stepping instruction |
| trap_req_i | input | 1 | Synchronous trap request |
| trap_num_i | input | 5 | Requested trap number |
| addr_fault_i | input | 1 | Request is address-related |
| fault_addr_i | input | DATA_W | Faulting virtual address |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | 0 status, 1 cause, 2 EPC, 3 bad address, 4 count, 5 compare, 6 FSR |
| wr_data_i | input | DATA_W | Write data |
| trap_taken_o | output | 1 | Trap taken this step (vector request) |
| trap_code_o | output | 5 | Code of the trap taken |
| status_o | output | 32 | Status word |
| cause_o | output | 32 | Cause word |
| epc_o | output | DATA_W | Exception PC |
| badaddr_o | output | DATA_W | Bad-address register |
| count_o | output | DATA_W | Step counter |
| compare_o | output | DATA_W | Timer compare |
| fsr_o | output | 32 | Floating-point status |
| xlen64_o | output | 1 | Effective integer width is 64 |
| error_o | output | 1 | Sticky fatal error |

## Verification
The trap decision is tried under several patterns:
- A masked pending line against an unmasked one, which separates the mask AND from a plain pending check.
- A pending line with traps disabled, which shows that interrupts never raise the error.
- An interrupt coinciding with a synchronous request, which exposes the priority.

Synchronous traps are issued from user and from supervisor mode, so that previous-supervisor is seen to copy the old mode rather than a constant. The same traps are run with and without the address flag. The two error causes are each run after their own reset, so the sticky flag cannot hide one of them. The counter is walked across the compare value, which shows that the match uses the pre-increment count and that the pending bit persists until compare is rewritten.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int SR_W     = 32;
  localparam int CODE_W   = 5;
  localparam int TE_BIT   = 0;
  localparam int EF_BIT   = 1;
  localparam int EC_BIT   = 2;
  localparam int EV_BIT   = 3;
  localparam int PS_BIT   = 4;
  localparam int S_BIT    = 5;
  localparam int UX_BIT   = 6;
  localparam int SX_BIT   = 7;
  localparam int IM_LO    = 16;
  localparam int LINES    = 8;
  localparam int CODE_LO  = 0;
  localparam int IP_LO    = 8;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_EPC     = 3'd2,
    SEL_BADADDR = 3'd3,
    SEL_COUNT   = 3'd4,
    SEL_COMPARE = 3'd5,
    SEL_FSR     = 3'd6
  } reg_sel_e;

  function automatic logic [SR_W-1:0] status_keep(input bit wide, input bit fpu,
                                                  input bit cmpr, input bit vec);
    logic [SR_W-1:0] m;
    m = '0;
    m[TE_BIT] = 1'b1;
    m[PS_BIT] = 1'b1;
    m[S_BIT]  = 1'b1;
    m[IM_LO +: LINES] = '1;
    m[EF_BIT] = fpu;
    m[EC_BIT] = cmpr;
    m[EV_BIT] = vec;
    m[UX_BIT] = wide;
    m[SX_BIT] = wide;
    return m;
  endfunction

  function automatic logic [SR_W-1:0] cause_keep();
    logic [SR_W-1:0] m;
    m = '0;
    m[IP_LO +: LINES] = '1;
    m[CODE_LO +: CODE_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/tc_status.sv
module tc_status
  import trap_ctrl_pkg::*;
#(
  parameter bit HAS_WIDE = 1'b1,
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_CMPR = 1'b0,
  parameter bit HAS_VEC  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  input  logic            trap_enter,
  output logic [SR_W-1:0] status,
  output logic            xlen64
);
  localparam logic [SR_W-1:0] KEEP = status_keep(HAS_WIDE, HAS_FPU, HAS_CMPR, HAS_VEC);
  localparam logic [SR_W-1:0] RESET_VAL = ((SR_W'(1) << S_BIT) | (SR_W'(1) << SX_BIT)) & KEEP;

  logic [SR_W-1:0] sr_q, sr_d, entered;

  always_comb begin
    entered = sr_q;
    entered[TE_BIT] = 1'b0;
    entered[PS_BIT] = sr_q[S_BIT];
    entered[S_BIT]  = 1'b1;
  end

  always_comb begin
    if (trap_enter)  sr_d = entered;
    else if (wr_en)  sr_d = wr_data & KEEP;
    else             sr_d = sr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= RESET_VAL;
    else        sr_q <= sr_d;
  end

  assign status = sr_q;
  assign xlen64 = sr_q[S_BIT] ? sr_q[SX_BIT] : sr_q[UX_BIT];

  // R3
  trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> (!status[TE_BIT] && status[S_BIT] && status[PS_BIT] == $past(status[S_BIT])));

  // R7
  status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~KEEP) == '0);
endmodule

// File: rtl/tc_timer.sv
module tc_timer #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              cnt_wr,
  input  logic              cmp_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] compare,
  output logic              hit
);
  logic [DATA_W-1:0] cnt_q, cmp_q;

  assign hit = step && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_wr)    cnt_q <= wr_data;
      else if (step) cnt_q <= cnt_q + 1'b1;
      if (cmp_wr)    cmp_q <= wr_data;
    end
  end

  assign count   = cnt_q;
  assign compare = cmp_q;

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/tc_cause.sv
module tc_cause
  import trap_ctrl_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int TIMER_LINE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_enter,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [DATA_W-1:0] pc,
  input  logic              fault_load,
  input  logic [DATA_W-1:0] fault_addr,
  input  logic              timer_hit,
  input  logic              cmp_wr,
  input  logic              cause_wr,
  input  logic              epc_wr,
  input  logic              bad_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SR_W-1:0]   cause,
  output logic [DATA_W-1:0] epc,
  output logic [DATA_W-1:0] badaddr
);
  localparam logic [SR_W-1:0] KEEP = cause_keep();
  localparam int TBIT = IP_LO + TIMER_LINE;

  logic [SR_W-1:0]   cause_q, cause_d;
  logic [DATA_W-1:0] epc_q, bad_q;

  always_comb begin
    cause_d = cause_q;
    if (trap_enter)    cause_d[CODE_LO +: CODE_W] = trap_code;
    else if (cause_wr) cause_d = wr_data[SR_W-1:0] & KEEP;
    if (cmp_wr)        cause_d[TBIT] = 1'b0;
    if (timer_hit)     cause_d[TBIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      bad_q   <= '0;
    end else begin
      cause_q <= cause_d;
      if (trap_enter)  epc_q <= pc;
      else if (epc_wr) epc_q <= wr_data;
      if (fault_load)  bad_q <= fault_addr;
      else if (bad_wr && !trap_enter) bad_q <= wr_data;
    end
  end

  assign cause   = cause_q;
  assign epc     = epc_q;
  assign badaddr = bad_q;

  // R4
  ip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && !timer_hit && !cmp_wr) |=> cause[IP_LO +: LINES] == $past(cause[IP_LO +: LINES]));

  // R10
  timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_hit |=> cause[TBIT]);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_ctrl_pkg::*;
#(
  parameter int          DATA_W     = 64,
  parameter int          NUM_TRAPS  = 16,
  parameter int          IRQ_CODE   = 0,
  parameter int          TIMER_LINE = 7,
  parameter bit          HAS_WIDE   = 1'b1,
  parameter bit          HAS_FPU    = 1'b1,
  parameter bit          HAS_CMPR   = 1'b0,
  parameter bit          HAS_VEC    = 1'b0,
  parameter logic [31:0] FSR_KEEP   = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              trap_req_i,
  input  logic [4:0]        trap_num_i,
  input  logic              addr_fault_i,
  input  logic [DATA_W-1:0] fault_addr_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              trap_taken_o,
  output logic [4:0]        trap_code_o,
  output logic [31:0]       status_o,
  output logic [31:0]       cause_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] badaddr_o,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] compare_o,
  output logic [31:0]       fsr_o,
  output logic              xlen64_o,
  output logic              error_o
);
  localparam logic [CODE_W:0]   NT       = (CODE_W+1)'(NUM_TRAPS);
  localparam logic [CODE_W-1:0] IRQ_C    = CODE_W'(IRQ_CODE);

  logic irq_pend, irq_take, num_ok, sync_ok, sync_bad, trap_enter;
  logic timer_hit, err_q;
  logic [31:0] fsr_q;
  logic [CODE_W-1:0] code;
  logic w_status, w_cause, w_epc, w_bad, w_count, w_cmp, w_fsr;

  assign irq_pend = |(cause_o[IP_LO +: LINES] & status_o[IM_LO +: LINES]);
  assign irq_take = step_i && status_o[TE_BIT] && irq_pend;
  assign num_ok   = {1'b0, trap_num_i} < NT;
  assign sync_ok  = step_i && trap_req_i && !irq_take && status_o[TE_BIT] && num_ok;
  assign sync_bad = step_i && trap_req_i && !irq_take && (!status_o[TE_BIT] || !num_ok);
  assign trap_enter = irq_take || sync_ok;
  assign code = irq_take ? IRQ_C : trap_num_i;

  assign w_status = wr_en_i && (wr_sel_i == SEL_STATUS)  && !trap_enter;
  assign w_cause  = wr_en_i && (wr_sel_i == SEL_CAUSE);
  assign w_epc    = wr_en_i && (wr_sel_i == SEL_EPC);
  assign w_bad    = wr_en_i && (wr_sel_i == SEL_BADADDR);
  assign w_count  = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign w_cmp    = wr_en_i && (wr_sel_i == SEL_COMPARE);
  assign w_fsr    = wr_en_i && (wr_sel_i == SEL_FSR);

  tc_status #(
    .HAS_WIDE(HAS_WIDE), .HAS_FPU(HAS_FPU), .HAS_CMPR(HAS_CMPR), .HAS_VEC(HAS_VEC)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(w_status), .wr_data(wr_data_i[SR_W-1:0]),
    .trap_enter(trap_enter), .status(status_o), .xlen64(xlen64_o)
  );

  tc_timer #(.DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .step(step_i), .cnt_wr(w_count), .cmp_wr(w_cmp),
    .wr_data(wr_data_i), .count(count_o), .compare(compare_o), .hit(timer_hit)
  );

  tc_cause #(.DATA_W(DATA_W), .TIMER_LINE(TIMER_LINE)) u_cause (
    .clk(clk), .rst_n(rst_n), .trap_enter(trap_enter), .trap_code(code), .pc(pc_i),
    .fault_load(sync_ok && addr_fault_i), .fault_addr(fault_addr_i),
    .timer_hit(timer_hit), .cmp_wr(w_cmp), .cause_wr(w_cause), .epc_wr(w_epc),
    .bad_wr(w_bad), .wr_data(wr_data_i), .cause(cause_o), .epc(epc_o), .badaddr(badaddr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      fsr_q <= '0;
    end else begin
      if (sync_bad) err_q <= 1'b1;
      if (w_fsr)    fsr_q <= wr_data_i[31:0] & FSR_KEEP;
    end
  end

  assign trap_taken_o = trap_enter;
  assign trap_code_o  = code;
  assign fsr_o        = fsr_q;
  assign error_o      = err_q;

  // R6
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);

  // R2
  trap_needs_te_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken_o |-> status_o[TE_BIT]);

  // R4
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken_o |=> epc_o == $past(pc_i));

  // R11
  fsr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_o & ~FSR_KEEP) == 32'h0);
endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic        trap_req_i = 1'b0;
  logic [4:0]  trap_num_i = '0;
  logic        addr_fault_i = 1'b0;
  logic [63:0] fault_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        trap_taken_o;
  logic [4:0]  trap_code_o;
  logic [31:0] status_o, cause_o, fsr_o;
  logic [63:0] epc_o, badaddr_o, count_o, compare_o;
  logic        xlen64_o, error_o;

  int checks = 0;
  int errors = 0;
  int traps_seen = 0;
  int cycles = 0;
  bit done = 0;
  int exp_q[$];

  trap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .pc_i(pc_i), .trap_req_i(trap_req_i),
    .trap_num_i(trap_num_i), .addr_fault_i(addr_fault_i), .fault_addr_i(fault_addr_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .trap_taken_o(trap_taken_o), .trap_code_o(trap_code_o), .status_o(status_o),
    .cause_o(cause_o), .epc_o(epc_o), .badaddr_o(badaddr_o), .count_o(count_o),
    .compare_o(compare_o), .fsr_o(fsr_o), .xlen64_o(xlen64_o), .error_o(error_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected trap code for each trap the design reports
  always @(negedge clk) begin
    if (rst_n && trap_taken_o) begin
      traps_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected trap: actual code %0d expected none", trap_code_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(trap_code_o) != e) begin
          errors++;
          $display("FAIL R2/R12 trap code: actual %0d expected %0d", trap_code_o, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic step(input logic [63:0] pc, input bit req, input int num,
                      input bit fault, input logic [63:0] fa, input bit expect_trap,
                      input int exp_code, input bit wen, input logic [2:0] sel,
                      input logic [63:0] data);
    if (expect_trap) exp_q.push_back(exp_code);
    step_i = 1'b1; pc_i = pc; trap_req_i = req; trap_num_i = 5'(num);
    addr_fault_i = fault; fault_addr_i = fa;
    wr_en_i = wen; wr_sel_i = sel; wr_data_i = data;
    @(posedge clk); #1;
    step_i = 1'b0; trap_req_i = 1'b0; addr_fault_i = 1'b0; wr_en_i = 1'b0;
  endtask

  initial begin
    int n0;
    do_reset();
    // R1 reset state
    chk("R1 status", 64'(status_o), 64'hA0);
    chk("R1 cause", 64'(cause_o), 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 badaddr", badaddr_o, 0);
    chk("R1 count", count_o, 0);
    chk("R1 compare", compare_o, 0);
    chk("R1 fsr", 64'(fsr_o), 0);
    chk("R1 error", 64'(error_o), 0);

    wr(3'd5, 64'd1000);
    // R7 masking of status and cause writes
    wr(3'd0, 64'hFFFF_FFFF);
    chk("R7 status mask", 64'(status_o), 64'h00FF_00F3);
    wr(3'd1, 64'hFFFF_FFFF);
    chk("R7 cause mask", 64'(cause_o), 64'h0000_FF1F);
    wr(3'd1, 64'h0);
    // R8 width selection
    wr(3'd0, 64'h21);  chk("R8 sup no wide", 64'(xlen64_o), 0);
    wr(3'd0, 64'hA1);  chk("R8 sup wide", 64'(xlen64_o), 1);
    wr(3'd0, 64'h41);  chk("R8 user wide", 64'(xlen64_o), 1);
    wr(3'd0, 64'h81);  chk("R8 user sx only", 64'(xlen64_o), 0);

    // R3 R4 R5 sync trap from user mode with address fault
    wr(3'd0, 64'h41);
    step(64'h100, 1, 3, 1, 64'hDEAD, 1, 3, 0, 0, 0);
    chk("R3 status user entry", 64'(status_o), 64'h60);
    chk("R4 cause code", 64'(cause_o), 64'h3);
    chk("R4 epc", epc_o, 64'h100);
    chk("R5 badaddr loaded", badaddr_o, 64'hDEAD);
    // R5 sync trap without fault keeps badaddr; from supervisor mode
    wr(3'd0, 64'h21);
    step(64'h140, 1, 9, 0, 64'hBEEF, 1, 9, 0, 0, 0);
    chk("R5 badaddr kept", badaddr_o, 64'hDEAD);
    chk("R3 status sup entry", 64'(status_o), 64'h30);

    // R2 masked pending line does not trap
    wr(3'd1, 64'h400);
    wr(3'd0, 64'h0080_0021);
    n0 = traps_seen;
    step(64'h1F0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 masked no trap", 64'(traps_seen - n0), 0);
    // R12 unmasked interrupt wins over sync request
    wr(3'd0, 64'h0004_0021);
    step(64'h200, 1, 5, 1, 64'h77, 1, 0, 0, 0, 0);
    chk("R12 status", 64'(status_o), 64'h0004_0030);
    chk("R4 ip kept", 64'(cause_o), 64'h400);
    chk("R4 epc irq", epc_o, 64'h200);
    chk("R12 badaddr untouched", badaddr_o, 64'hDEAD);
    chk("R12 no error", 64'(error_o), 0);
    // R2 pending and unmasked but trap-enable clear
    n0 = traps_seen;
    step(64'h204, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 te clear no trap", 64'(traps_seen - n0), 0);
    chk("R2 te clear no error", 64'(error_o), 0);

    // R9 R10 timer
    wr(3'd4, 64'd999);
    step(64'h300, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 no early hit", 64'(cause_o[15]), 0);
    chk("R9 count inc", count_o, 64'd1000);
    step(64'h304, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 hit sets pending", 64'(cause_o[15]), 1);
    chk("R9 count after hit", count_o, 64'd1001);
    step(64'h308, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 pending held", 64'(cause_o[15]), 1);
    wr(3'd5, 64'd5);
    chk("R10 compare write clears", 64'(cause_o[15]), 0);

    // R11 fsr
    wr(3'd6, 64'hFFFF_FFFF);
    chk("R11 fsr", 64'(fsr_o), 64'hFF);

    // R13 writes in a trap cycle ignored
    wr(3'd0, 64'h21);
    step(64'h400, 1, 2, 0, 0, 1, 2, 1, 3'd0, 64'hFFFF_FFFF);
    chk("R13 status write ignored", 64'(status_o), 64'h30);
    wr(3'd0, 64'h21);
    step(64'h404, 1, 4, 0, 0, 1, 4, 1, 3'd2, 64'h999);
    chk("R13 epc write ignored", epc_o, 64'h404);

    // R6 trap request with trap-enable clear
    do_reset();
    n0 = traps_seen;
    step(64'h500, 1, 1, 1, 64'h55, 0, 0, 0, 0, 0);
    chk("R6 te clear error", 64'(error_o), 1);
    chk("R6 te clear no trap", 64'(traps_seen - n0), 0);
    chk("R6 te clear epc", epc_o, 0);
    chk("R6 te clear badaddr", badaddr_o, 0);
    chk("R6 te clear status", 64'(status_o), 64'hA0);
    step(64'h504, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 error sticky", 64'(error_o), 1);

    // R6 trap number out of range
    do_reset();
    wr(3'd0, 64'h21);
    n0 = traps_seen;
    step(64'h600, 1, 20, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 bad number error", 64'(error_o), 1);
    chk("R6 bad number no trap", 64'(traps_seen - n0), 0);
    chk("R6 bad number status", 64'(status_o), 64'h21);

    chk("R2 all expected traps seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule